// File: doc/BRIEF.md
# Comparator Result Conditioner and Router

This block sits behind a one-bit analog comparator and turns its raw decision into a clean digital event. The raw bit first passes an enable gate and then an optional inversion. The result is then masked by a blanking window, which software picks from a set of timer compare outputs. Masking suppresses the short current spikes that appear at the start of each PWM period. The conditioned value always drives a pin-side output. It can also be steered onto one line of a destination vector that feeds timer break, capture or clear inputs.

The whole signal path from the raw bit to the pin and the destination lines is combinational. It does not depend on the bus clock and keeps working while that clock is stopped. Only the software-readable copy of the result is registered. It passes through a two-flop synchronizer into the bus clock domain.

Top module: `cmpout_shaper`

## Requirements
- R1: When `cfg_en` is 0, the raw comparator bit is treated as 0 before inversion, so the conditioned value equals `cfg_invert` unless blanking masks it.
- R2: With `cfg_en` at 1 and no blanking, the conditioned value equals `cmp_raw` when `cfg_invert` is 0 and equals its inverse when `cfg_invert` is 1.
- R3: A blanking code of 0 applies no mask. A code k from 1 to NBLK selects `blank_src[k-1]`, and while that line is high the conditioned value is forced to 0.
- R4: Blanking codes above NBLK are reserved and apply no mask, whatever the state of `blank_src`.
- R5: A route code of 0 drives no destination line. The legal route codes are 1, 2 and 5 through 11, and each drives destination line `dest_o[code]` with the conditioned value.
- R6: Reserved route codes (3, 4 and 12 through 15) drive no destination line. At most one destination line is high at any time, and line 0 is never high.
- R7: `pin_out` always carries the conditioned value, including while a destination line carries it too.
- R8: `pin_out` and `dest_o` follow changes on their inputs and configuration with no clock edge in between.
- R9: `state_rd` shows the conditioned value as sampled at the second rising `clk` edge after a change, and it is 0 after reset. With `cfg_en` at 1, `cfg_invert` at 0 and no blanking, a 1 means the non-inverting input is above the inverting input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock for the readable state synchronizer |
| rst_n | input | 1 | Active-low asynchronous reset of the synchronizer |
| cmp_raw | input | 1 | Raw comparator decision, 1 when the non-inverting input is higher |
| blank_src | input | NBLK | Candidate blanking windows from timer compare outputs, active high |
| cfg_en | input | 1 | Comparator enable |
| cfg_invert | input | 1 | Output inversion control |
| cfg_blank_sel | input | BSEL_W | Blanking window selection code |
| cfg_route | input | RSEL_W | Destination selection code |
| pin_out | output | 1 | Conditioned value toward the pin |
| dest_o | output | 2**RSEL_W | Destination lines toward timer inputs, one-hot or zero |
| state_rd | output | 1 | Synchronized conditioned value for software reads |

## Verification
The pin output and the destination lines are combinational. The bench checks them 1 ns after it drives new inputs on a falling clock edge, before any rising edge can occur. The readable state needs two rising edges. The bench therefore holds each stimulus steady across two rising edges and checks `state_rd` at the following falling edge. Random configurations come from a fixed seed. Directed cases cover the disabled comparator, reserved codes in both fields and the reset value.

// File: rtl/cmpout_pkg.sv
package cmpout_pkg;

  // Route codes that map to an existing timer-side destination
  function automatic logic route_legal(input int unsigned code);
    return (code == 1) || (code == 2) || ((code >= 5) && (code <= 11));
  endfunction

  // Conditioning arithmetic: gate, invert, then mask
  function automatic logic condition(input logic en, input logic inv,
                                     input logic raw, input logic mask);
    return ((en & raw) ^ inv) & ~mask;
  endfunction

endpackage

// File: rtl/cmpout_blank_mux.sv
module cmpout_blank_mux #(
  parameter int NBLK   = 4,
  parameter int BSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBLK-1:0]   src_i,
  input  logic [BSEL_W-1:0] sel_i,
  output logic              hit_o
);
  logic [NBLK-1:0] hit_vec;

  for (genvar k = 0; k < NBLK; k++) begin : g_cand
    assign hit_vec[k] = (sel_i == BSEL_W'(k + 1)) & src_i[k];
  end

  assign hit_o = |hit_vec;

  // R4
  reserved_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_i) > NBLK) |-> !hit_o);
  // R3
  no_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == '0) |-> !hit_o);
endmodule

// File: rtl/cmpout_router.sv
module cmpout_router #(
  parameter int RSEL_W = 4,
  localparam int NDEST = 1 << RSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              val_i,
  input  logic [RSEL_W-1:0] route_i,
  output logic [NDEST-1:0]  dest_o
);
  logic route_ok;

  assign route_ok = cmpout_pkg::route_legal(int'(route_i));

  for (genvar d = 0; d < NDEST; d++) begin : g_dest
    assign dest_o[d] = route_ok & val_i & (route_i == RSEL_W'(d));
  end

  // R6
  dest_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dest_o));
  // R6
  dest_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dest_o[0]);
  // R5
  dest_carries_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_o != '0) |-> val_i);
endmodule

// File: rtl/cmpout_sync.sv
module cmpout_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      age_q  <= 2'd0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
  end

  assign q_o = sync_q;

  // R9
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/cmpout_shaper.sv
module cmpout_shaper #(
  parameter int NBLK   = 4,
  parameter int BSEL_W = 3,
  parameter int RSEL_W = 4,
  localparam int NDEST = 1 << RSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_raw,
  input  logic [NBLK-1:0]   blank_src,
  input  logic              cfg_en,
  input  logic              cfg_invert,
  input  logic [BSEL_W-1:0] cfg_blank_sel,
  input  logic [RSEL_W-1:0] cfg_route,
  output logic              pin_out,
  output logic [NDEST-1:0]  dest_o,
  output logic              state_rd
);
  logic blank_hit;
  logic cond_val;

  cmpout_blank_mux #(.NBLK(NBLK), .BSEL_W(BSEL_W)) u_blank (
    .clk(clk), .rst_n(rst_n), .src_i(blank_src), .sel_i(cfg_blank_sel),
    .hit_o(blank_hit));

  assign cond_val = cmpout_pkg::condition(cfg_en, cfg_invert, cmp_raw, blank_hit);
  assign pin_out  = cond_val;

  cmpout_router #(.RSEL_W(RSEL_W)) u_route (
    .clk(clk), .rst_n(rst_n), .val_i(cond_val), .route_i(cfg_route),
    .dest_o(dest_o));

  cmpout_sync u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cond_val), .q_o(state_rd));

  // R3
  blank_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_hit |-> !pin_out);
  // R1
  disabled_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !blank_hit) |-> (pin_out == cfg_invert));
  // R7
  pin_matches_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_o != '0) |-> pin_out);
endmodule

// File: tb/cmpout_shaper_test.sv
`timescale 1ns/1ps
module cmpout_shaper_test;
  localparam int NBLK = 4;
  localparam int BSEL_W = 3;
  localparam int RSEL_W = 4;
  localparam int NDEST = 1 << RSEL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_raw = 1'b0;
  logic [NBLK-1:0] blank_src = '0;
  logic cfg_en = 1'b0, cfg_invert = 1'b0;
  logic [BSEL_W-1:0] cfg_blank_sel = '0;
  logic [RSEL_W-1:0] cfg_route = '0;
  logic pin_out, state_rd;
  logic [NDEST-1:0] dest_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cmpout_shaper #(.NBLK(NBLK), .BSEL_W(BSEL_W), .RSEL_W(RSEL_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .blank_src(blank_src),
    .cfg_en(cfg_en), .cfg_invert(cfg_invert), .cfg_blank_sel(cfg_blank_sel),
    .cfg_route(cfg_route), .pin_out(pin_out), .dest_o(dest_o),
    .state_rd(state_rd));

  function automatic bit model_out(bit en, bit inv, bit raw, int bsel, logic [NBLK-1:0] bs);
    bit v = en ? raw : 1'b0;
    if (inv) v = ~v;
    if (bsel >= 1 && bsel <= NBLK && bs[bsel-1]) v = 1'b0;
    return v;
  endfunction

  function automatic logic [NDEST-1:0] model_dest(int code, bit v);
    logic [NDEST-1:0] r = '0;
    case (code)
      1, 2, 5, 6, 7, 8, 9, 10, 11: r[code] = v;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, check combinational outputs, then the synchronized state
  task automatic apply(string req, bit raw, logic [NBLK-1:0] bs, bit en, bit inv,
                       int bsel, int route);
    bit ev;
    @(negedge clk);
    cmp_raw = raw; blank_src = bs; cfg_en = en; cfg_invert = inv;
    cfg_blank_sel = BSEL_W'(bsel); cfg_route = RSEL_W'(route);
    ev = model_out(en, inv, raw, bsel, bs);
    #1;
    check({req, " R7 R8 pin"}, 32'(pin_out), 32'(ev));
    check({req, " R5 R6 dest"}, 32'(dest_o), 32'(model_dest(route, ev)));
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check({req, " R9 state"}, 32'(state_rd), 32'(ev));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset", 32'(state_rd), 32'd0);
    check("R6 reset dest", 32'(dest_o), 32'd0);
    rst_n = 1'b1;
    // R1 disabled comparator
    apply("R1 off", 1, '0, 0, 0, 0, 1);
    apply("R1 off inv", 1, '0, 0, 1, 0, 2);
    apply("R1 off raw0 inv", 0, '0, 0, 1, 0, 5);
    // R2 polarity
    apply("R2 pass", 1, '0, 1, 0, 0, 6);
    apply("R2 invert", 1, '0, 1, 1, 0, 7);
    apply("R2 invert low", 0, '0, 1, 1, 0, 11);
    // R3 blanking per candidate
    for (int k = 1; k <= NBLK; k++) begin
      apply("R3 blank hit", 1, 4'(1 << (k - 1)), 1, 0, k, 1);
      apply("R3 other line", 1, ~4'(1 << (k - 1)), 1, 0, k, 1);
    end
    apply("R3 code zero", 1, '1, 1, 0, 0, 8);
    // R4 reserved blanking codes
    for (int c = NBLK + 1; c < (1 << BSEL_W); c++)
      apply("R4 reserved blank", 1, '1, 1, 0, c, 9);
    // R5 R6 every route code
    for (int r = 0; r < NDEST; r++) apply("R5 R6 route sweep", 1, '0, 1, 0, 0, r);
    // random mix
    for (int i = 0; i < 300; i++)
      apply("rand", 1'($urandom), NBLK'($urandom), 1'($urandom), 1'($urandom),
            int'($urandom_range(0, (1 << BSEL_W) - 1)),
            int'($urandom_range(0, NDEST - 1)));
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule